// File: doc/BRIEF.md
# Clock Supervisor with Emergency Divider

This block supervises the system clock of a PLL-based clock generator. It divides the VCO-rate clock `clk` by a programmable ratio to produce `clk_out`. It also falls back to a safe divide-by-16 whenever the clock is lost or the device wakes from sleep. The analog parts (PLL, VCO, oscillator) sit outside the block. They appear only as the `clk` input, a reference-oscillator tick pulse, and two health indications: `osc_ok` and `pll_lock`.

While in emergency, a lock counter counts reference ticks. After 2048 of them the block leaves emergency, raises its oscillator-lock flag and loads the divider from the stored control word. Software writes a control word made of a 2-bit mode and a 4-bit divider field. During emergency, a write takes effect at once unless it selects a bypass mode; a bypass write waits until the lock completes. Ratio changes only take effect at the end of an output period, so `clk_out` never carries a runt pulse.

A sleep request holds the core at once. The clock itself is only switched off once reconfiguration is over.

Top module: `clk_supervisor`

## Requirements
- R1: Reset and every entry to emergency set `emerg_flag`=1 and `osc_lock_flag`=0. The divider field in use (`div_act`) then becomes 4'hF, which gives a 16-cycle period with 8 cycles high.
- R2: Emergency ends on the clock edge that samples the 2048th `ref_tick` pulse counted while `osc_ok` is high. After 2047 such pulses the block is still in emergency.
- R3: A write made during emergency whose mode MSB is 1 retargets the divider at once. A write whose mode MSB is 0 (bypass, modes 00/01) leaves `mode_act` and the ratio unchanged until emergency ends.
- R4: A divider field k in 1..15 gives a `clk_out` period of k+1 `clk` cycles, high for floor((k+1)/2) cycles. A field of 0 is treated as 1 (period 2).
- R5: The ratio in use changes only at a period boundary. Every period around a ratio change has either the old length or the new one.
- R6: Clock failure is `pll_lock` or `osc_ok` low while out of emergency. It enters emergency and pulses `unlock_irq` for exactly one cycle. A `wake_evt` pulse also enters emergency but raises no `unlock_irq`.
- R7: On leaving emergency, `osc_lock_flag` becomes 1 and the divider and mode targets take the control word, including a deferred bypass write. The control word resets to mode 11, divider 1.
- R8: `osc_ok` going low during emergency restarts the lock count from zero.
- R9: `sleep_req` raises `core_hold` one cycle later. `clk_gated` rises only when the clock is stable (out of emergency, with the ratio in use equal to the target). While it is gated, `clk_out` stays low. During emergency, `clk_out` keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-rate clock, divided to form `clk_out` |
| rst_n | input | 1 | Active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference-oscillator tick |
| osc_ok | input | 1 | Oscillator amplitude good |
| pll_lock | input | 1 | PLL locked |
| wake_evt | input | 1 | Wake-up from sleep pulse |
| ctrl_we | input | 1 | Control-word write strobe |
| ctrl_wdata | input | 6 | Control word: [5:4] mode, [3:0] divider field |
| sleep_req | input | 1 | Request to enter sleep |
| clk_out | output | 1 | Divided clock |
| emerg_flag | output | 1 | Emergency mode active |
| osc_lock_flag | output | 1 | Oscillator lock reached |
| clk_stable | output | 1 | Reconfiguration complete |
| unlock_irq | output | 1 | One-cycle pulse on clock-failure entry |
| core_hold | output | 1 | Core and peripherals held for sleep |
| clk_gated | output | 1 | Divided clock switched off for sleep |
| mode_act | output | 2 | Mode currently in force |
| div_act | output | 4 | Divider field currently in use |

## Verification
The bench hunts for off-by-one errors in the lock count. A counter that finishes one tick early or late would leave emergency after the 2047th pulse, or still be in it after the 2048th. A drop of `osc_ok` placed 1000 ticks into a count shows whether the counter really restarts: without a restart, emergency would end 1000 ticks too soon. Emergency-time writes are split by mode MSB, which exposes a design that applies bypass writes early or defers all writes. Periods measured across every ratio change catch a divider that switches mid-period and emits a runt. Sleep requests made during emergency catch a design that gates the clock before reconfiguration ends.

// File: rtl/clk_supervisor_pkg.sv
package clk_supervisor_pkg;

  // widest divider field the helpers accept
  localparam int unsigned FIELD_MAX_W = 8;

  typedef logic [FIELD_MAX_W:0]   span_t;
  typedef logic [FIELD_MAX_W-1:0] field_t;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_FAIL = 2'd1,
    CAUSE_WAKE = 2'd2
  } entry_cause_t;

  // period in source cycles for a divider field; zero is treated as one
  function automatic span_t div_span(input field_t k);
    span_t eff;
    eff = (k == '0) ? span_t'(1) : span_t'(k);
    return eff + span_t'(1);
  endfunction

  // cycles high within one period
  function automatic span_t div_high(input field_t k);
    return div_span(k) >> 1;
  endfunction

endpackage

// File: rtl/clk_supervisor_lock_ctr.sv
module clk_supervisor_lock_ctr #(
  parameter int unsigned LOCK_TICKS = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic osc_ok,
  input  logic tick,
  output logic done
);
  localparam int unsigned CW = (LOCK_TICKS > 2) ? $clog2(LOCK_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(LOCK_TICKS - 1);

  logic [CW-1:0] count;

  assign done = run && osc_ok && tick && (count == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (!run || !osc_ok || done) begin
      count <= '0;
    end else if (tick) begin
      count <= count + CW'(1);
    end
  end
endmodule

// File: rtl/clk_supervisor_ctl.sv
module clk_supervisor_ctl #(
  parameter int unsigned DIV_W  = 4,
  parameter int unsigned MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pll_lock,
  input  logic              osc_ok,
  input  logic              wake_evt,
  input  logic              we,
  input  logic [MODE_W-1:0] wmode,
  input  logic [DIV_W-1:0]  wdiv,
  input  logic              lock_done,
  output logic              emerg,
  output logic              osc_lk,
  output logic              irq,
  output logic [MODE_W-1:0] tgt_mode,
  output logic [DIV_W-1:0]  tgt_div
);
  import clk_supervisor_pkg::*;

  logic [MODE_W-1:0] ctl_mode;
  logic [DIV_W-1:0]  ctl_div;
  logic              fail;
  logic              w_bypass;
  entry_cause_t      cause;

  assign fail     = !emerg && (!pll_lock || !osc_ok);
  assign w_bypass = !wmode[MODE_W-1];

  always_comb begin
    if (fail)          cause = CAUSE_FAIL;
    else if (wake_evt) cause = CAUSE_WAKE;
    else               cause = CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emerg    <= 1'b1;
      osc_lk   <= 1'b0;
      irq      <= 1'b0;
      ctl_mode <= '1;
      ctl_div  <= DIV_W'(1);
      tgt_mode <= '1;
      tgt_div  <= '1;
    end else begin
      irq <= 1'b0;
      if (we) begin
        ctl_mode <= wmode;
        ctl_div  <= wdiv;
      end
      if (cause != CAUSE_NONE) begin
        emerg   <= 1'b1;
        osc_lk  <= 1'b0;
        tgt_div <= '1;
        irq     <= (cause == CAUSE_FAIL);
      end else if (emerg && lock_done) begin
        emerg    <= 1'b0;
        osc_lk   <= 1'b1;
        tgt_mode <= we ? wmode : ctl_mode;
        tgt_div  <= we ? wdiv  : ctl_div;
      end else if (we && (!emerg || !w_bypass)) begin
        tgt_mode <= wmode;
        tgt_div  <= wdiv;
      end
    end
  end
endmodule

// File: rtl/clk_supervisor_divider.sv
module clk_supervisor_divider #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [DIV_W-1:0] tgt,
  output logic             clk_out,
  output logic [DIV_W-1:0] cur,
  output logic             period_last
);
  import clk_supervisor_pkg::*;

  logic [DIV_W-1:0] cnt, cnt_n, cur_n;
  field_t           cur_f, nxt_f;
  span_t            per_cur, per_m1, hi_n;
  logic             out_n;

  always_comb begin
    cur_f = '0;
    cur_f[DIV_W-1:0] = cur;
    per_cur = div_span(cur_f);
    per_m1  = per_cur - span_t'(1);
    period_last = (span_t'(cnt) == per_m1);
    if (period_last) begin
      cnt_n = '0;
      cur_n = tgt;
    end else begin
      cnt_n = cnt + DIV_W'(1);
      cur_n = cur;
    end
    nxt_f = '0;
    nxt_f[DIV_W-1:0] = cur_n;
    hi_n  = div_high(nxt_f);
    out_n = span_t'(cnt_n) < hi_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '1;
      cur     <= '1;
      clk_out <= 1'b0;
    end else if (hold) begin
      cnt     <= per_m1[DIV_W-1:0];
      clk_out <= 1'b0;
    end else begin
      cnt     <= cnt_n;
      cur     <= cur_n;
      clk_out <= out_n;
    end
  end
endmodule

// File: rtl/clk_supervisor.sv
module clk_supervisor #(
  parameter int unsigned DIV_W      = 4,
  parameter int unsigned MODE_W     = 2,
  parameter int unsigned LOCK_TICKS = 2048
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_tick,
  input  logic                    osc_ok,
  input  logic                    pll_lock,
  input  logic                    wake_evt,
  input  logic                    ctrl_we,
  input  logic [MODE_W+DIV_W-1:0] ctrl_wdata,
  input  logic                    sleep_req,
  output logic                    clk_out,
  output logic                    emerg_flag,
  output logic                    osc_lock_flag,
  output logic                    clk_stable,
  output logic                    unlock_irq,
  output logic                    core_hold,
  output logic                    clk_gated,
  output logic [MODE_W-1:0]       mode_act,
  output logic [DIV_W-1:0]        div_act
);
  logic             lock_done;
  logic             period_last;
  logic [DIV_W-1:0] tgt_div;

  clk_supervisor_lock_ctr #(.LOCK_TICKS(LOCK_TICKS)) u_lock (
    .clk(clk), .rst_n(rst_n), .run(emerg_flag), .osc_ok(osc_ok),
    .tick(ref_tick), .done(lock_done)
  );

  clk_supervisor_ctl #(.DIV_W(DIV_W), .MODE_W(MODE_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .pll_lock(pll_lock), .osc_ok(osc_ok),
    .wake_evt(wake_evt), .we(ctrl_we),
    .wmode(ctrl_wdata[MODE_W+DIV_W-1:DIV_W]), .wdiv(ctrl_wdata[DIV_W-1:0]),
    .lock_done(lock_done), .emerg(emerg_flag), .osc_lk(osc_lock_flag),
    .irq(unlock_irq), .tgt_mode(mode_act), .tgt_div(tgt_div)
  );

  clk_supervisor_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .hold(clk_gated), .tgt(tgt_div),
    .clk_out(clk_out), .cur(div_act), .period_last(period_last)
  );

  assign clk_stable = !emerg_flag && (div_act == tgt_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_hold <= 1'b0;
      clk_gated <= 1'b0;
    end else begin
      core_hold <= sleep_req;
      clk_gated <= sleep_req && clk_stable;
    end
  end
endmodule

// File: rtl/clk_supervisor_checker.sv
module clk_supervisor_checker #(
  parameter int unsigned DIV_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             emerg_flag,
  input logic             osc_lock_flag,
  input logic             unlock_irq,
  input logic             clk_stable,
  input logic             clk_gated,
  input logic             clk_out,
  input logic [DIV_W-1:0] div_act,
  input logic [DIV_W-1:0] tgt_div,
  input logic             period_last,
  input logic             lock_done
);
  assert_entry_forces_max_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(emerg_flag) |-> (tgt_div == '1 && !osc_lock_flag));

  assert_exit_on_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(emerg_flag) |-> $past(lock_done));

  assert_ratio_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_act) |-> $past(period_last));

  assert_irq_in_emergency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_irq |-> (emerg_flag && !osc_lock_flag));

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_irq |=> !unlock_irq);

  assert_lock_on_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(emerg_flag) |-> osc_lock_flag);

  assert_gate_needs_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_gated) |-> $past(clk_stable));

  assert_gated_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clk_gated) |-> !clk_out);
endmodule

bind clk_supervisor clk_supervisor_checker #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/clk_supervisor_bench.sv
module clk_supervisor_bench;
  // 50 MHz: 20 time units per cycle
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0, osc_ok = 1'b1, pll_lock = 1'b1, wake_evt = 1'b0;
  logic       ctrl_we = 1'b0, sleep_req = 1'b0;
  logic [5:0] ctrl_wdata = '0;
  logic       clk_out, emerg_flag, osc_lock_flag, clk_stable, unlock_irq;
  logic       core_hold, clk_gated;
  logic [1:0] mode_act;
  logic [3:0] div_act;

  always #10 clk = ~clk;

  clk_supervisor u_clk_supervisor (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .osc_ok(osc_ok),
    .pll_lock(pll_lock), .wake_evt(wake_evt), .ctrl_we(ctrl_we),
    .ctrl_wdata(ctrl_wdata), .sleep_req(sleep_req), .clk_out(clk_out),
    .emerg_flag(emerg_flag), .osc_lock_flag(osc_lock_flag),
    .clk_stable(clk_stable), .unlock_irq(unlock_irq), .core_hold(core_hold),
    .clk_gated(clk_gated), .mode_act(mode_act), .div_act(div_act)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {int per; int hi; string tag;} exp_t;
  exp_t q[$];

  int cyc = 0, last_rise = 0, last_fall = 0;
  bit seen_rise = 0, prev_out = 0, watch = 0;
  int allow_a = 0, allow_b = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, expv, cyc);
    end
  endtask

  // expected waveform computed from the requirement text
  function automatic int exp_per(input int k);
    return (k == 0) ? 2 : k + 1;
  endfunction
  function automatic int exp_hi(input int k);
    return exp_per(k) / 2;
  endfunction

  // monitor: measure each completed period and compare against the queue
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!clk_out && prev_out) last_fall = cyc;
      if (clk_out && !prev_out) begin
        if (seen_rise) begin
          if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk((cyc - last_rise) == e.per && (last_fall - last_rise) == e.hi, e.tag,
                (cyc - last_rise) * 100 + (last_fall - last_rise), e.per * 100 + e.hi);
          end else if (watch) begin
            chk((cyc - last_rise) == allow_a || (cyc - last_rise) == allow_b,
                "R5 period across change", cyc - last_rise, allow_b);
          end
        end
        seen_rise = 1;
        last_rise = cyc;
      end
    end
    prev_out = clk_out;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_wave(input int k, input string tag);
    idle(40);
    repeat (3) q.push_back('{exp_per(k), exp_hi(k), tag});
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] m, input logic [3:0] d);
    @(negedge clk);
    ctrl_we = 1'b1;
    ctrl_wdata = {m, d};
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk) ref_tick = 1'b1;
      @(negedge clk) ref_tick = 1'b0;
    end
  endtask

  // write with R5 glitch watch from old field to new field
  task automatic wr_watch(input int old_k, input int new_k, input string tag);
    allow_a = exp_per(old_k);
    allow_b = exp_per(new_k);
    watch = 1;
    wr(2'b11, 4'(new_k));
    idle(40);
    watch = 0;
    expect_wave(new_k, tag);
  endtask

  task automatic full_lock(input string tag);
    ticks(2047);
    chk(emerg_flag == 1'b1, {tag, " R2 still emergency after 2047"}, emerg_flag, 1);
    ticks(1);
    chk(emerg_flag == 1'b0, {tag, " R2 exit after 2048"}, emerg_flag, 0);
    chk(osc_lock_flag == 1'b1, {tag, " R7 lock flag"}, osc_lock_flag, 1);
  endtask

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(emerg_flag == 1'b1, "R1 reset emergency", emerg_flag, 1);
    chk(osc_lock_flag == 1'b0, "R1 reset lock flag", osc_lock_flag, 0);
    chk(div_act == 4'hF, "R1 reset divider", div_act, 15);
    chk(unlock_irq == 1'b0, "R6 no irq at reset", unlock_irq, 0);
    expect_wave(15, "R1 divide-by-16 in emergency");

    full_lock("first lock");
    chk(mode_act == 2'b11, "R7 reset mode", mode_act, 3);
    expect_wave(1, "R7 reset divider target");

    // R4 and R5: normal writes
    wr_watch(1, 3, "R4 field 3");
    wr_watch(3, 2, "R4 field 2 odd period");
    wr_watch(2, 0, "R4 field 0 treated as 1");
    wr_watch(0, 4, "R4 field 4");
    wr_watch(4, 15, "R4 field 15");
    wr_watch(15, 7, "R4 field 7");

    // R6 failure entry
    @(negedge clk) pll_lock = 1'b0;
    @(negedge clk);
    chk(emerg_flag == 1'b1, "R6 failure enters emergency", emerg_flag, 1);
    chk(unlock_irq == 1'b1, "R6 irq on failure", unlock_irq, 1);
    chk(osc_lock_flag == 1'b0, "R1 lock flag cleared", osc_lock_flag, 0);
    pll_lock = 1'b1;
    @(negedge clk);
    chk(unlock_irq == 1'b0, "R6 irq one cycle", unlock_irq, 0);
    idle(40);
    chk(div_act == 4'hF, "R1 forced max after failure", div_act, 15);

    // R3 writes during emergency
    wr(2'b10, 4'd3);
    chk(div_act == 4'hF || emerg_flag == 1'b1, "R3 still emergency", emerg_flag, 1);
    expect_wave(3, "R3 PLL-mode write immediate");
    wr(2'b00, 4'd5);
    idle(40);
    chk(mode_act == 2'b10, "R3 bypass mode deferred", mode_act, 2);
    expect_wave(3, "R3 bypass divider deferred");

    // R8 restart on osc_ok drop
    ticks(1000);
    @(negedge clk) osc_ok = 1'b0;
    idle(2);
    osc_ok = 1'b1;
    full_lock("R8 after restart");
    chk(mode_act == 2'b00, "R7 deferred bypass mode applied", mode_act, 0);
    expect_wave(5, "R7 deferred bypass divider applied");

    // R6 wake entry
    @(negedge clk) wake_evt = 1'b1;
    @(negedge clk) wake_evt = 1'b0;
    chk(emerg_flag == 1'b1, "R6 wake enters emergency", emerg_flag, 1);
    chk(unlock_irq == 1'b0, "R6 no irq on wake", unlock_irq, 0);

    // R9 sleep during emergency
    sleep_req = 1'b1;
    @(negedge clk);
    chk(core_hold == 1'b1, "R9 core hold", core_hold, 1);
    idle(30);
    chk(clk_gated == 1'b0, "R9 no gating in emergency", clk_gated, 0);
    expect_wave(15, "R9 clock runs during emergency");
    full_lock("sleep lock");
    idle(40);
    chk(clk_gated == 1'b1, "R9 gated after reconfiguration", clk_gated, 1);
    begin
      int highs = 0;
      repeat (20) begin
        @(negedge clk);
        if (clk_out) highs++;
      end
      chk(highs == 0, "R9 clock low while gated", highs, 0);
    end
    sleep_req = 1'b0;
    idle(3);
    chk(clk_gated == 1'b0 && core_hold == 1'b0, "R9 release", clk_gated, 0);
    expect_wave(5, "R9 clock resumes");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule